// File: doc/BRIEF.md
# UART Baud Rate Clock Generator

This block makes the baud-rate clock enable for a UART. One 8-bit configuration register holds two settings: a source select, which picks the base tick, and a 5-bit divisor k. The base tick is either the system clock prescaled by 2, 8 or 32, or the rising edges of an external timer output. A programmable counter divides the base tick by k. A final halving stage then produces `baud_tick`, which is a single-cycle enable in the system clock domain. No derived clocks are made anywhere.

Software writes the register over a simple write port and can read it back. The divisor is locked while the UART transmitter or receiver is enabled. Any write that changes the stored register value restarts the prescaler and the divider, so the first baud period after a change is always complete.

Top module: `uart_baud_gen`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0x1F (source code 00, divisor code 31) and `baud_tick` is 0.
- R2: `rd_data` returns the source select in bits 7:6 and the divisor code in bits 4:0. Bit 5 always reads 0, whatever value was written to it.
- R3: The source code in bits 7:6 picks the base tick: 00 is the timer input, 01 is every 2nd cycle, 10 is every 8th cycle and 11 is every 32nd cycle. The internal prescale factor P is therefore 2, 8 or 32.
- R4: For divisor codes 8 to 31, k equals the code. With an internal source, `baud_tick` repeats every 2·k·P cycles.
- R5: Divisor codes 0 to 7 behave exactly as k = 8.
- R6: A write made while `tx_en` or `rx_en` is 1 keeps the old divisor code. Bits 7:6 are still written in that case.
- R7: After a write that changes the stored register value, the first `baud_tick` is high in the cycle following the (2·k·P+1)-th clock edge after the write edge.
- R8: A write that leaves the stored value unchanged does not disturb the phase of `baud_tick`.
- R9: The timer input passes through a two-stage synchronizer. Each rising edge gives one base tick, so a timer period of T cycles yields a `baud_tick` period of 2·k·T cycles.
- R10: `baud_tick` is high for one cycle at a time, and two consecutive pulses are never closer than 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read-back value |
| tx_en | input | 1 | Transmitter enabled; locks the divisor |
| rx_en | input | 1 | Receiver enabled; locks the divisor |
| tmr_in | input | 1 | External timer output used as a base source |
| baud_tick | output | 1 | One-cycle baud clock enable |

## Verification
The spacing check assumes that the timer input holds each level for at least one full clock cycle. Under that assumption, edges after synchronization arrive no more often than every second cycle. The bench's timer stimulus toggles every two cycles, so it stays inside that assumption. All other register traffic comes from single-cycle write strobes, driven on the falling clock edge. Every write the bench uses to measure a first period changes the stored value. The one deliberate same-value write is made while the outputs are counted, so the unchanged phase can be observed.

// File: rtl/ubg_pkg.sv
// Package: shared types for the baud generator.
// Assumes: the source select field is 2 bits wide and uses the code order below.
package ubg_pkg;
    typedef enum logic [1:0] {
        SRC_TMR   = 2'b00,
        SRC_PRE_A = 2'b01,
        SRC_PRE_B = 2'b10,
        SRC_PRE_C = 2'b11
    } src_e;

    typedef struct packed {
        src_e       src;
        logic [4:0] kcode;
    } cfg_t;
endpackage

// File: rtl/ubg_cfg_reg.sv
// Module: configuration register.
// Holds the source select and the divisor code. The divisor code is locked
// while tx_en or rx_en is set. A one-cycle restart pulse follows any write
// that changes the stored value.
// Assumes: wr_en is a single-cycle strobe in the clk domain.
module ubg_cfg_reg
    import ubg_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h1F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tx_en,
    input  logic       rx_en,
    output cfg_t       cfg,
    output logic       restart,
    output logic [7:0] rd_data
);
    cfg_t nxt_cfg;
    logic div_lock;

    // Form the candidate value; the divisor field is held while locked.
    always_comb begin
        div_lock      = tx_en | rx_en;
        nxt_cfg.src   = src_e'(wr_data[7:6]);
        nxt_cfg.kcode = div_lock ? cfg.kcode : wr_data[4:0];
    end

    // Store the configuration and flag a value change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.src   <= src_e'(RST_VAL[7:6]);
            cfg.kcode <= RST_VAL[4:0];
            restart   <= 1'b0;
        end else begin
            restart <= wr_en && (nxt_cfg != cfg);
            if (wr_en) begin
                cfg <= nxt_cfg;
            end
        end
    end

    // Read-back view; bit 5 has no storage.
    assign rd_data = {cfg.src, 1'b0, cfg.kcode};
endmodule

// File: rtl/ubg_prescale.sv
// Module: base tick source.
// Makes three clock enables from a free-running counter, plus a
// synchronized rising-edge pulse from the timer input, and selects one of them.
// Assumes: tmr_in is asynchronous and holds each level for at least one cycle.
module ubg_prescale
    import ubg_pkg::*;
#(
    parameter int unsigned SH_A  = 1,
    parameter int unsigned SH_B  = 3,
    parameter int unsigned SH_C  = 5,
    parameter int unsigned SYNC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  src_e src,
    input  logic tmr_in,
    output logic base_tick
);
    localparam int unsigned PRE_W  = SH_C;
    localparam int unsigned N_PRE  = 3;
    localparam int unsigned SH [N_PRE] = '{SH_A, SH_B, SH_C};

    logic [PRE_W-1:0] pre_cnt;
    logic [N_PRE-1:0] pre_en;
    logic [SYNC:0]    tmr_sh;
    logic             tmr_edge;

    // Free-running prescale counter, cleared on a configuration change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // One enable per prescale factor: high when the low bits are all ones.
    for (genvar g = 0; g < N_PRE; g++) begin : g_pre
        assign pre_en[g] = &pre_cnt[SH[g]-1:0];
    end

    // Synchronizer chain followed by one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_sh <= '0;
        end else begin
            tmr_sh <= {tmr_sh[SYNC-1:0], tmr_in};
        end
    end

    assign tmr_edge = tmr_sh[SYNC-1] & ~tmr_sh[SYNC];

    // Pick the base tick for the selected source.
    always_comb begin
        unique case (src)
            SRC_TMR:   base_tick = tmr_edge;
            SRC_PRE_A: base_tick = pre_en[0];
            SRC_PRE_B: base_tick = pre_en[1];
            default:   base_tick = pre_en[2];
        endcase
    end
endmodule

// File: rtl/ubg_divider.sv
// Module: programmable divider and halving stage.
// Counts base ticks modulo k (codes below K_MIN are clamped up), toggles a
// half-phase flag at each wrap, and emits baud_tick on every second wrap.
// Assumes: restart is asserted for one cycle after any configuration change.
module ubg_divider #(
    parameter int unsigned DIV_W = 5,
    parameter int unsigned K_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] kcode,
    output logic             baud_tick
);
    localparam logic [DIV_W-1:0] K_FLOOR = DIV_W'(K_MIN);

    logic [DIV_W-1:0] k_eff;
    logic [DIV_W-1:0] cnt;
    logic             half;
    logic             last;

    // Clamp prohibited codes and find the terminal count.
    always_comb begin
        k_eff = (kcode < K_FLOOR) ? K_FLOOR : kcode;
        last  = (cnt == k_eff - 1'b1);
    end

    // Divide-by-k counter, halving flag and registered output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt       <= '0;
            half      <= 1'b0;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= base_tick && last && half;
            if (base_tick) begin
                if (last) begin
                    cnt  <= '0;
                    half <= ~half;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_baud_gen.sv
// Module: UART baud clock generator (top).
// Connects the configuration register, the base tick source and the divider.
// Assumes: a single clock domain; tmr_in is the only asynchronous input.
module uart_baud_gen
    import ubg_pkg::*;
#(
    parameter logic [7:0]  RST_VAL = 8'h1F,
    parameter int unsigned DIV_W   = 5,
    parameter int unsigned K_MIN   = 8,
    parameter int unsigned SYNC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       tmr_in,
    output logic       baud_tick
);
    cfg_t cfg;
    logic restart;
    logic base_tick;

    ubg_cfg_reg #(.RST_VAL(RST_VAL)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tx_en   (tx_en),
        .rx_en   (rx_en),
        .cfg     (cfg),
        .restart (restart),
        .rd_data (rd_data)
    );

    ubg_prescale #(.SYNC(SYNC)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .src       (cfg.src),
        .tmr_in    (tmr_in),
        .base_tick (base_tick)
    );

    ubg_divider #(.DIV_W(DIV_W), .K_MIN(K_MIN)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .base_tick (base_tick),
        .kcode     (cfg.kcode),
        .baud_tick (baud_tick)
    );
endmodule

// File: rtl/uart_baud_gen_chk.sv
// Module: assertion checker bound to uart_baud_gen.
// Assumes: tmr_in holds each level for at least one clock cycle.
module uart_baud_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tx_en,
    input logic       rx_en,
    input logic       baud_tick
);
    logic [11:0] gap;
    logic        seen;

    // Count cycles since the previous pulse, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (baud_tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 12'hFFF) begin
            gap <= gap + 1'b1;
        end
    end

    AST_BIT5_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[5]); // R2
    AST_SRC_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[7:6] == $past(wr_data[7:6])); // R6
    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (tx_en || rx_en) |=> rd_data[4:0] == $past(rd_data[4:0])); // R6
    AST_DIV_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !tx_en && !rx_en |=> rd_data[4:0] == $past(wr_data[4:0])); // R2
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick); // R10
    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick && seen |-> gap >= 12'd31); // R10
endmodule

bind uart_baud_gen uart_baud_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .baud_tick (baud_tick)
);

// File: tb/uart_baud_gen_tb_top.sv
// Bench: sweeps every internal source and every legal divisor, then covers
// clamped codes, the divisor lock, a same-value write and the timer source.
module uart_baud_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       tmr_in = 1'b0;
    logic       tmr_run = 1'b0;
    logic       baud_tick;
    int         errors = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    uart_baud_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .tmr_in    (tmr_in),
        .baud_tick (baud_tick)
    );

    // Timer stimulus: toggles every two cycles, giving a period of four.
    initial forever begin
        repeat (2) @(negedge clk);
        if (tmr_run) tmr_in = ~tmr_in;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Count falling edges until baud_tick is seen high.
    task automatic next_tick(input int limit, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (baud_tick || n >= limit) break;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h1F, "R1 reset value", rd_data, 8'h1F);
        check(!baud_tick, "R1 reset tick", baud_tick, 0);

        // R3 R4 R7: every internal source with every legal divisor.
        for (int s = 1; s <= 3; s++) begin
            for (int k = 8; k <= 31; k++) begin
                int p;
                p = 1 << (2 * s - 1);
                wr({s[1:0], 1'b0, k[4:0]});
                next_tick(5000, n);
                check(n == 2*k*p + 1, "R7 first period", n, 2*k*p + 1);
                next_tick(5000, n);
                check(n == 2*k*p, "R4 R3 steady period", n, 2*k*p);
                if (s == 1 && k == 8) begin
                    @(negedge clk);
                    check(!baud_tick, "R10 single cycle", baud_tick, 0);
                end
            end
        end

        // R2: bit 5 is not stored.
        wr(8'hFF);
        check(rd_data == 8'hDF, "R2 readback", rd_data, 8'hDF);

        // R5: prohibited codes act as k = 8.
        wr(8'h40);
        next_tick(5000, n);
        check(n == 33, "R5 code 0", n, 33);
        wr(8'h67);
        check(rd_data == 8'h47, "R2 bit5 masked", rd_data, 8'h47);
        next_tick(5000, n);
        check(n == 33, "R5 code 7", n, 33);

        // R6: divisor locked by tx_en, source still written.
        tx_en = 1'b1;
        wr(8'hD4);
        check(rd_data == 8'hC7, "R6 tx lock", rd_data, 8'hC7);
        next_tick(5000, n);
        check(n == 513, "R6 kept divisor", n, 513);
        tx_en = 1'b0;
        rx_en = 1'b1;
        wr(8'h5E);
        check(rd_data == 8'h47, "R6 rx lock", rd_data, 8'h47);
        next_tick(5000, n);
        check(n == 33, "R6 rx period", n, 33);
        rx_en = 1'b0;

        // R8: same-value write mid-period keeps the phase.
        wr(8'h4A);
        next_tick(5000, n);
        check(n == 41, "R8 setup", n, 41);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 10) begin
                wr_en   = 1'b1;
                wr_data = 8'h4A;
            end else begin
                wr_en = 1'b0;
            end
            if (baud_tick || n >= 5000) break;
        end
        check(n == 40, "R8 phase kept", n, 40);

        // R9: timer source, period 4 cycles.
        tmr_run = 1'b1;
        wr(8'h08);
        next_tick(5000, n);
        next_tick(5000, n);
        check(n == 64, "R9 timer k8", n, 64);
        wr(8'h0C);
        next_tick(5000, n);
        next_tick(5000, n);
        check(n == 96, "R9 timer k12", n, 96);
        next_tick(5000, n);
        check(n == 96, "R9 timer repeat", n, 96);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule